// File: doc/BRIEF.md
# Stuck Bus Timeout and Recovery Clocker

This block watches the synchronized SDA and SCL lines on the downstream side of a two-wire bus buffer. It looks for a bus that stays stuck low. A timer counts every system-clock cycle in which either line is low, and the timer clears only in a cycle where both lines are high. When the count reaches a set timeout, the block drives its active-low fault output low. At the same moment it asks the surrounding buffer to break the path between the upstream and downstream sides.

After a set settling delay, the block drives a burst of recovery clocks on the downstream SCL through an open-drain pull-down enable. Each clock is low for one half-period and released for the next, so the burst has a 50% duty cycle. A burst holds at most a set number of pulses. The burst ends early if both lines are seen high while SCL is released, and the fault then clears. If the bus is still stuck after a full burst, the fault stays asserted and the timer runs again for another attempt. While power-good is low the block sits in lockout. A bus that is already stuck when power-good rises gets the same treatment, counted from the end of lockout. Every duration is a parameter in system-clock cycles: `TIMEOUT_CYC`, `DELAY_CYC`, `HALF_CYC` and `PULSE_MAX`.

The controller has six states. The transitions are:
- LOCK goes to WATCH when power-good is high.
- WATCH goes to HOLD_OFF when the timer expires.
- HOLD_OFF goes to WATCH when the bus is idle, and to DRIVE_LO when the delay ends.
- DRIVE_LO goes to DRIVE_HI when its half-period ends.
- DRIVE_HI goes to WATCH when the bus is idle. When its half-period ends it goes back to DRIVE_LO, or to REARM once the burst is complete.
- REARM goes to WATCH when the bus is idle, and to HOLD_OFF when the timer expires.
- Any state goes to LOCK when power-good is low.

Top module: `bus_unstick_ctrl`

## Requirements
- R1: While `pwr_ok` is low, and during reset, `fault_n` is 1, `disconnect` is 0 and `scl_pull` is 0. The stuck timer is held clear, so a stuck bus raises no fault. Dropping `pwr_ok` while in fault releases the fault one cycle later.
- R2: `fault_n` falls after exactly `TIMEOUT_CYC` consecutive sampled cycles in which `sda_s` and `scl_s` were not both 1. A shorter run raises no fault.
- R3: The timer clears only in a cycle where `sda_s` and `scl_s` are both 1. Lows that alternate between the two lines, with never both high, still time out at `TIMEOUT_CYC`. A single both-high cycle restarts the count.
- R4: `disconnect` is always the inverse of `fault_n`.
- R5: The first `scl_pull` pulse starts exactly `DELAY_CYC` cycles after `fault_n` falls.
- R6: `scl_pull` is 1 for exactly `HALF_CYC` cycles and then 0 for `HALF_CYC` cycles between pulses. It is 1 only while `fault_n` is 0.
- R7: One recovery attempt drives at most `PULSE_MAX` pulses.
- R8: When `sda_s` and `scl_s` are both 1 while in fault and `scl_pull` is 0, `fault_n` returns to 1 on the next cycle and no further pulses follow.
- R9: If the bus is still stuck after `PULSE_MAX` pulses, `fault_n` stays 0. The next burst starts `HALF_CYC + TIMEOUT_CYC + DELAY_CYC` cycles after the last pulse ends.
- R10: With the bus stuck when `pwr_ok` rises, `fault_n` falls `TIMEOUT_CYC + 1` cycles after the first clock edge that sees `pwr_ok` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Power-good; low holds the block in lockout |
| sda_s | input | 1 | Synchronized downstream SDA level |
| scl_s | input | 1 | Synchronized downstream SCL level |
| fault_n | output | 1 | Active-low stuck-bus fault |
| disconnect | output | 1 | Request to break the upstream/downstream path |
| scl_pull | output | 1 | Open-drain pull-down enable for downstream SCL |

## Verification
The bench sweeps the length of a stuck-low run from one cycle up to two cycles past the timeout. An off-by-one timer would show up as a fault one cycle early, or as a fault missing at the exact boundary. It alternates the low between SDA and SCL. A timer that cleared when one line was merely high would never fault under this stimulus. It sweeps the pulse after which the bus frees, from zero pulses (freed during the delay) up to the last pulse. A design that ignored the freed bus would keep clocking, and one that checked the bus while pulling SCL low could never release. It also measures the delay, the half-periods, the gap before a second attempt, and the power-up timeout, each against values computed from the parameters.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

    typedef enum logic [2:0] {
        ST_LOCK,
        ST_WATCH,
        ST_HOLD_OFF,
        ST_DRIVE_LO,
        ST_DRIVE_HI,
        ST_REARM
    } unstick_state_t;

    function automatic logic is_fault_state(input unstick_state_t s);
        return (s == ST_HOLD_OFF) || (s == ST_DRIVE_LO) ||
               (s == ST_DRIVE_HI) || (s == ST_REARM);
    endfunction

endpackage

// File: rtl/bu_stuck_timer.sv
module bu_stuck_timer #(
    parameter int TIMEOUT_CYC = 3_750_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic busy,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Counts cycles with either line low; any both-high cycle clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || !busy) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && busy && (cnt_q == LAST);

endmodule

// File: rtl/bu_phase_timer.sv
module bu_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == limit);

endmodule

// File: rtl/bu_pulse_count.sv
module bu_pulse_count #(
    parameter int PULSE_MAX = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear,
    input  logic                             incr,
    output logic [$clog2(PULSE_MAX+1)-1:0]   cnt,
    output logic                             last
);
    localparam int PW = $clog2(PULSE_MAX + 1);
    localparam logic [PW-1:0] FULL = PW'(PULSE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (incr && (cnt != FULL)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == FULL);

endmodule

// File: rtl/bus_unstick_ctrl.sv
module bus_unstick_ctrl
    import bus_unstick_pkg::*;
#(
    parameter int TIMEOUT_CYC = 3_750_000,
    parameter int DELAY_CYC   = 5_000,
    parameter int HALF_CYC    = 7_353,
    parameter int PULSE_MAX   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic sda_s,
    input  logic scl_s,
    output logic fault_n,
    output logic disconnect,
    output logic scl_pull
);
    localparam int PH_MAX = (DELAY_CYC > HALF_CYC) ? DELAY_CYC : HALF_CYC;
    localparam int PH_W   = $clog2(PH_MAX) + 1;
    localparam int PC_W   = $clog2(PULSE_MAX + 1);
    localparam logic [PH_W-1:0] DELAY_LIM = PH_W'(DELAY_CYC - 1);
    localparam logic [PH_W-1:0] HALF_LIM  = PH_W'(HALF_CYC - 1);

    unstick_state_t state_q, state_d;

    logic            bus_idle;
    logic            timer_run;
    logic            timer_expired;
    logic            ph_restart;
    logic [PH_W-1:0] ph_limit;
    logic            ph_done;
    logic            pc_clear;
    logic            pc_incr;
    logic [PC_W-1:0] pulse_cnt;
    logic            pc_last;

    assign bus_idle  = sda_s && scl_s;
    assign timer_run = (state_q == ST_WATCH) || (state_q == ST_REARM);

    bu_stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) stuck_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .busy    (!bus_idle),
        .expired (timer_expired)
    );

    assign ph_restart = (state_d != state_q);
    assign ph_limit   = (state_q == ST_HOLD_OFF) ? DELAY_LIM : HALF_LIM;

    bu_phase_timer #(.W(PH_W)) phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ph_restart),
        .limit   (ph_limit),
        .done    (ph_done)
    );

    assign pc_clear = (state_d == ST_HOLD_OFF);
    assign pc_incr  = (state_q == ST_DRIVE_LO) && (state_d == ST_DRIVE_HI);

    bu_pulse_count #(.PULSE_MAX(PULSE_MAX)) pulses_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pc_clear),
        .incr  (pc_incr),
        .cnt   (pulse_cnt),
        .last  (pc_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCK: begin
                if (pwr_ok) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (timer_expired) state_d = ST_HOLD_OFF;
            end
            ST_HOLD_OFF: begin
                if (bus_idle)     state_d = ST_WATCH;
                else if (ph_done) state_d = ST_DRIVE_LO;
            end
            ST_DRIVE_LO: begin
                if (ph_done) state_d = ST_DRIVE_HI;
            end
            ST_DRIVE_HI: begin
                if (bus_idle)     state_d = ST_WATCH;
                else if (ph_done) state_d = pc_last ? ST_REARM : ST_DRIVE_LO;
            end
            ST_REARM: begin
                if (bus_idle)           state_d = ST_WATCH;
                else if (timer_expired) state_d = ST_HOLD_OFF;
            end
            default: state_d = ST_LOCK;
        endcase
        if (!pwr_ok) state_d = ST_LOCK;
    end

    // Outputs decoded from state
    always_comb begin
        fault_n    = !is_fault_state(state_q);
        disconnect = is_fault_state(state_q);
        scl_pull   = (state_q == ST_DRIVE_LO);
    end

endmodule

// File: rtl/bu_checker.sv
module bu_checker #(
    parameter int HALF_CYC  = 7_353,
    parameter int PULSE_MAX = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           pwr_ok,
    input logic                           sda_s,
    input logic                           scl_s,
    input logic                           fault_n,
    input logic                           disconnect,
    input logic                           scl_pull,
    input logic [$clog2(PULSE_MAX+1)-1:0] pulse_cnt
);
    logic [31:0] pull_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pull_run <= '0;
        else if (!scl_pull)                  pull_run <= '0;
        else if (pull_run != 32'hFFFF_FFFF)  pull_run <= pull_run + 1'b1;
    end

    p_lockout_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (fault_n && !scl_pull && !disconnect));

    p_fault_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past(!(sda_s && scl_s)));

    p_disc_inverse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect != fault_n);

    p_pull_in_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> !fault_n);

    p_pull_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= 32'(HALF_CYC));

    p_pulse_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pulse_cnt) <= 32'(PULSE_MAX));

    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && !scl_pull && sda_s && scl_s && pwr_ok) |=> fault_n);

endmodule

bind bus_unstick_ctrl bu_checker #(
    .HALF_CYC  (HALF_CYC),
    .PULSE_MAX (PULSE_MAX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .sda_s      (sda_s),
    .scl_s      (scl_s),
    .fault_n    (fault_n),
    .disconnect (disconnect),
    .scl_pull   (scl_pull),
    .pulse_cnt  (pulse_cnt)
);

// File: tb/bus_unstick_ctrl_tb.sv
`timescale 1ns/1ps
module bus_unstick_ctrl_tb_top;
    localparam int T = 20;
    localparam int D = 5;
    localparam int H = 3;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic sda_ext = 1'b1;
    logic scl_ext = 1'b1;
    logic sda_s, scl_s;
    logic fault_n, disconnect, scl_pull;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    // Open-drain bus model: downstream SCL is low if the block pulls it.
    assign sda_s = sda_ext;
    assign scl_s = scl_ext & ~scl_pull;

    bus_unstick_ctrl #(
        .TIMEOUT_CYC(T), .DELAY_CYC(D), .HALF_CYC(H), .PULSE_MAX(P)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .sda_s(sda_s), .scl_s(scl_s),
        .fault_n(fault_n), .disconnect(disconnect), .scl_pull(scl_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pull(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (scl_pull !== lvl && n < 2000);
    endtask

    task automatic wait_fault(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (fault_n !== lvl && n < 2000);
    endtask

    task automatic count_rises(input int cycles, output int rises);
        logic prev;
        prev = scl_pull;
        rises = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (scl_pull && !prev) rises++;
            prev = scl_pull;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, first, r;
        // Reset state (R1, R4)
        repeat (3) @(negedge clk);
        check(fault_n && !disconnect && !scl_pull, "R1 reset outputs",
              {fault_n, disconnect, scl_pull}, 3'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(fault_n === 1'b1, "R1 idle after reset", fault_n, 1);

        // R2 sweep of stuck-run length
        for (int len = 1; len <= T + 2; len++) begin
            first = 0;
            sda_ext = 1'b0;
            for (int i = 1; i <= len; i++) begin
                @(negedge clk);
                if (first == 0 && fault_n == 1'b0) begin
                    first = i;
                    check(disconnect === 1'b1, "R4 disconnect with fault", disconnect, 1);
                end
            end
            sda_ext = 1'b1;
            check(first == ((len >= T) ? T : 0), "R2 timeout boundary", first,
                  (len >= T) ? T : 0);
            repeat (12) @(negedge clk);
            check(fault_n === 1'b1, "R8 release after sweep run", fault_n, 1);
        end

        // R3 alternating lows never both high
        first = 0;
        for (int i = 1; i <= 2 * T; i++) begin
            sda_ext = i[0];
            scl_ext = ~i[0];
            @(negedge clk);
            if (first == 0 && fault_n == 1'b0) first = i;
        end
        sda_ext = 1'b1;
        scl_ext = 1'b1;
        check(first == T, "R3 alternating lows time out", first, T);
        repeat (12) @(negedge clk);

        // R3 one both-high cycle restarts the count
        first = 0;
        sda_ext = 1'b0;
        for (int i = 1; i <= 2 * T - 1; i++) begin
            sda_ext = (i == T) ? 1'b1 : 1'b0;
            scl_ext = (i > T) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (first == 0 && fault_n == 1'b0) first = i;
        end
        sda_ext = 1'b1;
        scl_ext = 1'b1;
        check(first == 0, "R3 idle cycle restarts timer", first, 0);
        repeat (4) @(negedge clk);

        // Full burst with SDA held low (R5, R6, R7, R9)
        sda_ext = 1'b0;
        wait_fault(1'b0, n);
        check(n == T, "R2 stuck SDA fault time", n, T);
        wait_pull(1'b1, n);
        check(n == D, "R5 delay before first pulse", n, D);
        for (int k = 0; k < P; k++) begin
            wait_pull(1'b0, n);
            check(n == H, "R6 pull low width", n, H);
            check(fault_n === 1'b0, "R6 pulse only in fault", fault_n, 0);
            if (k < P - 1) begin
                wait_pull(1'b1, n);
                check(n == H, "R6 released width", n, H);
            end
        end
        first = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (fault_n !== 1'b0) first = 1;
        end while (scl_pull !== 1'b1 && n < 2000);
        check(n == H + T + D, "R7 R9 burst cap and retry gap", n, H + T + D);
        check(first == 0, "R9 fault held across retry", first, 0);
        wait_pull(1'b0, n);
        sda_ext = 1'b1;
        wait_fault(1'b1, n);
        check(n == 1, "R8 release after retry pulse", n, 1);
        repeat (4) @(negedge clk);

        // R8 early stop sweep: bus frees after k pulses (k=0 during delay)
        for (int k = 0; k <= P; k++) begin
            sda_ext = 1'b0;
            wait_fault(1'b0, n);
            if (k == 0) begin
                @(negedge clk);
                sda_ext = 1'b1;
                @(negedge clk);
                check(fault_n === 1'b1, "R8 freed during delay", fault_n, 1);
            end else begin
                for (int j = 1; j <= k; j++) begin
                    wait_pull(1'b1, n);
                    if (j < k) wait_pull(1'b0, n);
                end
                sda_ext = 1'b1;
                wait_pull(1'b0, n);
                wait_fault(1'b1, n);
                check(n == 1, "R8 release one cycle after pull ends", n, 1);
            end
            count_rises(2 * (T + D + 2 * H), r);
            check(r == 0, "R8 no pulses after bus frees", r, 0);
            check(fault_n === 1'b1, "R8 fault stays released", fault_n, 1);
        end

        // R1 and R10: lockout with stuck bus, then power-good rises
        pwr_ok = 1'b0;
        sda_ext = 1'b0;
        first = 0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (!fault_n || scl_pull || disconnect) first = 1;
        end
        check(first == 0, "R1 lockout ignores stuck bus", first, 0);
        pwr_ok = 1'b1;
        wait_fault(1'b0, n);
        check(n == T + 1, "R10 power-up stuck timeout", n, T + 1);
        pwr_ok = 1'b0;
        @(negedge clk);
        check(fault_n && !disconnect && !scl_pull, "R1 lockout clears fault",
              {fault_n, disconnect, scl_pull}, 3'b100);
        sda_ext = 1'b1;
        pwr_ok = 1'b1;
        repeat (4) @(negedge clk);
        check(fault_n === 1'b1, "R1 idle after lockout", fault_n, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule